// File: doc/BRIEF.md
# Two-Wire Register Slave with Programmable Bus Address

This block is a two-wire serial slave that lets a bus host read and write a bank of 8-bit registers held outside the block. It oversamples SCL and SDA on a fast system clock and recognises START, repeated START and STOP. It compares the incoming 7-bit bus address against its own address and acknowledges only on a match. It drives SDA through an open-drain pull-low enable. A write carries a pointer byte, and any data bytes that follow go to the register that pointer selects. A read with no pointer byte returns the register under the pointer that the slave still holds from earlier. A host that does not know the pointer's value writes a pointer byte, issues a repeated START and then reads.

The slave's own bus address has two parts. The five upper bits live in an internal address register, which is reachable through the bus at one fixed pointer value. The two lower bits always follow two strap inputs. A change written to the upper bits is held back until the STOP that ends the write. The surrounding register file connects through a pointer output, a write-data output with a one-cycle write strobe, and a read-data input that is sampled combinationally.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), `reg_we_o` is 0, the pointer `reg_addr_o` is 0x00, and the upper five address bits are 01011, so the slave answers to {01011, strap_i[1:0]}.
- R2: The slave pulls SDA low in the ninth clock of an address byte only when byte bits 7..1 equal its address. For a non-matching address it never drives SDA, and it writes nothing until the next START.
- R3: In a write (address byte with bit 0 = 0), the slave takes the second byte as the pointer. Each further byte produces exactly one single-cycle `reg_we_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. The slave ACKs every byte it receives.
- R4: A write transaction that ends after the pointer byte loads the pointer and produces no write strobe.
- R5: The pointer keeps its value across STOP. A read (address byte with bit 0 = 1) returns the register at the held pointer, most significant bit first.
- R6: After a pointer byte, a repeated START followed by a read returns the register at the new pointer.
- R7: Pointer value 0x48 selects the internal address register. A write there produces no `reg_we_o`, and data bits 6..2 become the new upper address bits while bits 7, 1 and 0 are ignored. A read there returns {0, upper bits, strap_i}.
- R8: A new upper address takes effect only at the STOP that follows its write. Before that STOP, for example after a repeated START, the old address still matches.
- R9: A START or STOP in the middle of a byte abandons that byte with no write strobe. After such a START, the slave takes the next byte as an address byte.
- R10: During a read, a host ACK makes the slave send the same register again, because the pointer does not increment. A host NACK makes the slave release SDA and ignore the bus until the next START.
- R11: Address bits 1..0 follow `strap_i` directly, with no write needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Strap pins giving address bits 1..0 |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Write data for the register file |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |

## Verification
Each SCL edge passes through the two synchronizer flops and one edge-detect flop, and the state register then adds one more cycle. So SDA drive and the write strobe come about four system cycles after the SCL edge that triggers them. The bench holds every SCL phase for six system cycles and samples ACK bits and read data in the middle of the high phase, well after that latency. An address change is due one cycle after the STOP is detected, and register contents are compared only after the STOP phase has fully passed. Strobe-free cases are checked by counting strobes across the whole transaction.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;  // index 1 = scl, 0 = sda

  logic [NLINES-1:0] line_in, cur, prv;
  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic              last_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '1;
        last_q <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], line_in[g]};
        last_q <= pipe_q[STAGES-1];
      end
    end
    assign cur[g] = pipe_q[STAGES-1];
    assign prv[g] = last_q;
  end

  assign sda_o      = cur[0];
  assign scl_rise_o = cur[1] & ~prv[1];
  assign scl_fall_o = ~cur[1] & prv[1];
  assign start_o    = cur[1] & prv[1] & prv[0] & ~cur[0];
  assign stop_o     = cur[1] & prv[1] & ~prv[0] & cur[0];
endmodule

// File: rtl/tw_addr_reg.sv
module tw_addr_reg #(
  parameter int DW      = 8,
  parameter int AW      = 7,
  parameter int STRAP_W = 2,
  parameter logic [AW-STRAP_W-1:0] RESET_HI = 5'b01011
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               commit_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [AW-1:0]      addr_o,
  output logic [DW-1:0]      rdata_o
);
  localparam int HI_W = AW - STRAP_W;

  logic [HI_W-1:0] hi_q, pend_q;
  logic            pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= RESET_HI;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (wr_i) begin
      pend_q   <= wdata_i[AW-1:STRAP_W];
      pend_v_q <= 1'b1;
    end else if (commit_i && pend_v_q) begin
      hi_q     <= pend_q;
      pend_v_q <= 1'b0;
    end
  end

  assign addr_o  = {hi_q, strap_i};
  assign rdata_o = {{(DW-AW){1'b0}}, hi_q, strap_i};

  // address only moves on a STOP
  assert_commit_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(hi_q));
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 7,
  parameter int STRAP_W     = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-1:0]           ADDR_REG = 8'h48,
  parameter logic [AW-STRAP_W-1:0]   RESET_HI = 5'b01011
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [DW-1:0]      reg_addr_o,
  output logic [DW-1:0]      reg_wdata_o,
  output logic               reg_we_o,
  input  logic [DW-1:0]      reg_rdata_i
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tw_state_e         state_q, next_q;
  logic [DW-1:0]     sh_q, ptr_q, wdata_q;
  logic [CW-1:0]     cnt_q;
  logic              we_q, nack_q;
  logic [AW-1:0]     dev_addr;
  logic [DW-1:0]     ar_rdata, rd_byte;
  logic              rx_state, byte_done, addr_hit, ar_wr;

  assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDATA);
  assign byte_done = rx_state && scl_fall && (cnt_q == CNT_FULL);
  assign addr_hit  = (sh_q[DW-1:1] == dev_addr);
  assign ar_wr     = byte_done && (state_q == ST_WDATA) && (ptr_q == ADDR_REG) && !start_det && !stop_det;
  assign rd_byte   = (ptr_q == ADDR_REG) ? ar_rdata : reg_rdata_i;

  tw_addr_reg #(.DW(DW), .AW(AW), .STRAP_W(STRAP_W), .RESET_HI(RESET_HI)) u_addr (
    .clk_i, .rst_ni,
    .wr_i(ar_wr), .wdata_i(sh_q), .commit_i(stop_det),
    .strap_i, .addr_o(dev_addr), .rdata_o(ar_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      next_q  <= ST_IDLE;
      sh_q    <= '0;
      ptr_q   <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise && cnt_q != CNT_FULL) begin
              sh_q  <= {sh_q[DW-2:0], sda_s};
              cnt_q <= cnt_q + CW'(1);
            end else if (byte_done) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  state_q <= ST_ACK;
                  next_q  <= sh_q[0] ? ST_RDATA : ST_PTR;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                if (state_q == ST_PTR) ptr_q <= sh_q;
                else if (ptr_q != ADDR_REG) begin
                  we_q    <= 1'b1;
                  wdata_q <= sh_q;
                end
                state_q <= ST_ACK;
                next_q  <= ST_WDATA;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            state_q <= next_q;
            cnt_q   <= '0;
            if (next_q == ST_RDATA) sh_q <= rd_byte;
          end
          ST_RDATA: if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              state_q <= ST_RACK;
              cnt_q   <= '0;
            end else begin
              sh_q  <= {sh_q[DW-2:0], 1'b0};
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_RACK: begin
            if (scl_rise) nack_q <= sda_s;
            if (scl_fall) begin
              if (nack_q) state_q <= ST_IDLE;
              else begin
                sh_q    <= rd_byte;
                state_q <= ST_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = (state_q == ST_ACK) || (state_q == ST_RDATA && !sh_q[DW-1]);
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;

  assert_we_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  assert_no_we_addrreg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_addr_o != ADDR_REG);
  assert_start_restarts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_ADDR) && (cnt_q == '0) && !reg_we_o);
  assert_stop_idles_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE) && !sda_oe_o);
endmodule

// File: tb/tw_reg_slave_test.sv
`timescale 1ns/1ps
module tw_reg_slave_test;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_h = 1'b1, sda_h = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       bus_sda;

  logic [7:0] mem   [256];
  logic [7:0] exp_m [256];
  int wcount = 0;
  int checks = 0, errors = 0;
  logic [4:0] dev_hi = 5'b01011;
  bit done = 0;

  always #2 clk = ~clk;

  assign bus_sda   = sda_h & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  tw_reg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(bus_sda), .strap_i(strap),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      wcount <= wcount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_h = 1; wq(); scl_h = 1; wq(); sda_h = 0; wq(); scl_h = 0; wq(); endtask
  task automatic bus_stop(); sda_h = 0; wq(); scl_h = 1; wq(); sda_h = 1; wq(); wq(); endtask
  task automatic bit_out(input logic b); sda_h = b; wq(); scl_h = 1; wq(); wq(); scl_h = 0; wq(); endtask
  task automatic bit_in(output logic b); sda_h = 1; wq(); scl_h = 1; wq(); b = bus_sda; wq(); scl_h = 0; wq(); endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = !a;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit host_ack);
    logic b;
    for (int i = 0; i < 8; i++) begin bit_in(b); v = {v[6:0], b}; end
    bit_out(!host_ack);
  endtask

  function automatic logic [6:0] dev(); return {dev_hi, strap}; endfunction

  task automatic probe(input logic [6:0] a, output bit ack);
    bus_start(); send_byte({a, 1'b0}, ack); bus_stop();
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d);
    bit a0, a1, a2;
    bus_start(); send_byte({dev(), 1'b0}, a0); send_byte(p, a1); send_byte(d, a2); bus_stop();
    check(a0 && a1 && a2, "R3 write acks", {a0, a1, a2}, 3'b111);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bit a0, a1;
    bus_start(); send_byte({dev(), 1'b0}, a0); send_byte(p, a1); bus_stop();
    check(a0 && a1, "R4 pointer acks", {a0, a1}, 2'b11);
  endtask

  task automatic rd_cur(output logic [7:0] v);
    bit a0;
    bus_start(); send_byte({dev(), 1'b1}, a0); recv_byte(v, 1'b0); bus_stop();
    check(a0, "R5 read addr ack", a0, 1);
  endtask

  task automatic rd_rs(input logic [7:0] p, output logic [7:0] v);
    bit a0, a1, a2;
    bus_start(); send_byte({dev(), 1'b0}, a0); send_byte(p, a1);
    bus_start(); send_byte({dev(), 1'b1}, a2); recv_byte(v, 1'b0); bus_stop();
    check(a0 && a1 && a2, "R6 restart acks", {a0, a1, a2}, 3'b111);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack, a0, a1, a2, a3;
    logic [7:0] v, v2;
    int wc;
    logic [7:0] p, d;
    for (int i = 0; i < 256; i++) exp_m[i] = 8'(i * 37 + 5);
    repeat (4) @(negedge clk);
    check(!sda_oe && !reg_we && reg_addr == 0, "R1 reset outputs", {sda_oe, reg_we, reg_addr}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!sda_oe && reg_addr == 0, "R1 after reset", {sda_oe, reg_addr}, 0);

    // R2: full address sweep, strap = 01
    wc = wcount;
    for (int a = 0; a < 128; a++) begin
      probe(7'(a), ack);
      check(ack == (7'(a) == {5'b01011, 2'b01}), "R2 address match", ack, 7'(a) == 7'b0101101);
    end
    check(wcount == wc, "R2 no writes", wcount, wc);

    // R11: strap sweep
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int lo = 0; lo < 4; lo++) begin
        probe({5'b01011, 2'(lo)}, ack);
        check(ack == (lo == s), "R11 strap bits", ack, lo == s);
      end
    end
    strap = 2'b10;

    // R3: single-byte writes
    for (int k = 0; k < 8; k++) begin
      p = 8'(k * 29 + 3); d = 8'(k * 53 + 17);
      wc = wcount;
      wr_reg(p, d); exp_m[p] = d;
      check(wcount == wc + 1, "R3 one strobe", wcount - wc, 1);
      check(mem[p] == d, "R3 data written", mem[p], d);
    end

    // R5: current-pointer read, pointer held across STOP
    rd_cur(v);  check(v == exp_m[206], "R5 held pointer read", v, exp_m[206]);
    rd_cur(v);  check(v == exp_m[206], "R5 repeat read", v, exp_m[206]);

    // R6: repeated-START reads
    for (int k = 0; k < 6; k++) begin
      p = 8'(k * 41 + 7);
      rd_rs(p, v);  check(v == exp_m[p], "R6 restart read", v, exp_m[p]);
      rd_cur(v);    check(v == exp_m[p], "R5 pointer kept", v, exp_m[p]);
    end

    // R4: pointer-only write
    wc = wcount;
    set_ptr(8'd90);
    check(wcount == wc, "R4 no strobe", wcount, wc);
    rd_cur(v); check(v == exp_m[90], "R4 pointer moved", v, exp_m[90]);

    // R10: ACK continues same register, NACK releases
    bus_start(); send_byte({dev(), 1'b1}, a0);
    recv_byte(v, 1'b1); recv_byte(v2, 1'b0);
    check(!sda_oe, "R10 released after NACK", sda_oe, 0);
    bus_stop();
    check(a0 && v == exp_m[90] && v2 == exp_m[90], "R10 repeated byte", {v, v2}, {exp_m[90], exp_m[90]});

    // R3: multi-byte write all acked, same pointer
    wc = wcount;
    bus_start(); send_byte({dev(), 1'b0}, a0); send_byte(8'd33, a1);
    send_byte(8'hA1, a2); send_byte(8'h5B, a3); bus_stop();
    exp_m[33] = 8'h5B;
    check(a0 && a1 && a2 && a3, "R3 all bytes acked", {a0, a1, a2, a3}, 4'hF);
    check(wcount == wc + 2 && mem[33] == 8'h5B, "R3 two strobes", wcount - wc, 2);

    // R7/R8: address register
    wc = wcount;
    bus_start(); send_byte({dev(), 1'b0}, a0); send_byte(8'h48, a1); send_byte(8'hDC, a2);
    bus_start(); send_byte({dev(), 1'b1}, a3); recv_byte(v, 1'b0); bus_stop();
    check(a0 && a1 && a2 && a3, "R8 old address before STOP", {a0, a1, a2, a3}, 4'hF);
    check(v == 8'h2E, "R8 old value before STOP", v, 8'h2E);
    check(wcount == wc, "R7 no external strobe", wcount, wc);
    probe({5'b01011, strap}, ack);
    check(!ack, "R8 old address dropped", ack, 0);
    dev_hi = 5'b10111;
    probe(dev(), ack);
    check(ack, "R7 new address", ack, 1);
    rd_rs(8'h48, v); check(v == 8'h5E, "R7 readback", v, 8'h5E);
    strap = 2'b01;
    rd_cur(v); check(v == 8'h5D, "R11 readback follows strap", v, 8'h5D);
    wr_reg(8'h48, 8'hA7);
    dev_hi = 5'b01001;
    rd_cur(v); check(v == 8'h25, "R7 bits 7,1,0 ignored", v, 8'h25);
    check(wcount == wc, "R7 still no strobe", wcount, wc);

    // R9: START mid-byte, then address reception
    wc = wcount;
    bus_start(); send_byte({dev(), 1'b0}, a0); send_byte(8'd61, a1);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_start(); send_byte({dev(), 1'b0}, a2); bus_stop();
    check(a0 && a1 && a2, "R9 address after START abort", {a0, a1, a2}, 3'b111);
    check(wcount == wc && mem[61] == exp_m[61], "R9 no write on START", wcount, wc);
    // R9: STOP mid-byte
    bus_start(); send_byte({dev(), 1'b0}, a0); send_byte(8'd61, a1);
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    bus_stop();
    check(wcount == wc && mem[61] == exp_m[61], "R9 no write on STOP", wcount, wc);
    rd_cur(v); check(v == exp_m[61], "R9 slave recovers", v, exp_m[61]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule